// File: doc/BRIEF.md
# Double-Buffered Serial Character Receiver

This block takes an asynchronous serial input line, brings it into the local clock domain, and rebuilds characters of a fixed width (7, 8 or 9 data bits, chosen by parameter) from it. The data bits arrive least significant bit first. Each bit is timed by a programmable divisor. An optional parity bit and one stop bit follow the data. Once a character is complete, it is copied into a holding register. That register keeps its value while the next character is shifted in, so the host has a full character time to collect it.

The host reads the holding register whenever the ready flag is set, and pulses a read strobe to say the character has been taken. The flags for framing and parity errors belong to the character in the holding register. An overrun flag records that a character completed while the previous one was still unread. An interrupt request, gated by an enable input, follows the ready flag.

Top module: `serial_rx_dbuf`

## Requirements
- R1: The line passes through a two-stage synchroniser. A low level starts a frame only if it is still low half a bit time later. A shorter low pulse produces no character, and the receiver then accepts the next valid frame.
- R2: One bit time is divisor+1 clock cycles. Every bit after the start bit is sampled once near its centre. Characters are received correctly with divisor values of 4, 7 and 15.
- R3: Data bits are assembled least significant bit first, so the first data bit on the line appears on rd_data bit 0.
- R4: When a frame's stop bit has been sampled and the ready flag is clear, the character is loaded into the holding register and rd_ready goes to 1.
- R5: While a following character is being shifted in, rd_data keeps the earlier character.
- R6: A one-cycle rd_strobe clears rd_ready and overrun on the next clock edge. rd_data keeps its value after the read.
- R7: If a character completes while rd_ready is 1, overrun goes to 1. The new character is dropped, and rd_data, frame_err and parity_err are left unchanged.
- R8: A stop bit sampled low sets frame_err for that character. The receiver then waits for the line to return high before it looks for a new start bit.
- R9: When parity_en is 1, one parity bit follows the data. For even parity (parity_odd=0) the expected bit is the XOR of the data bits; for odd parity it is the inverse of that. A mismatch sets parity_err. When parity_en is 0, no parity bit is expected and parity_err stays 0.
- R10: irq is 1 exactly when rd_ready is 1 and irq_en is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| divisor | input | DIV_W | Bit time minus one, in clocks |
| parity_en | input | 1 | Expect a parity bit after the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| irq_en | input | 1 | Interrupt enable |
| rd_strobe | input | 1 | Host has read the holding register |
| rd_data | output | DATA_BITS | Holding register contents |
| rd_ready | output | 1 | Unread character present |
| overrun | output | 1 | A character was dropped because the holding register was unread |
| frame_err | output | 1 | Stop bit of the held character was low |
| parity_err | output | 1 | Parity bit of the held character mismatched |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench sends a low glitch shorter than half a bit. A receiver that never confirms the start bit would take this glitch as a character and raise rd_ready. It sends two characters with no read between them and checks rd_data in the middle of the second frame and again afterwards. A design that overwrote the holding register on overrun, or copied the shift register into it too early, would show the second character there. A frame with a low stop bit is sent with the line kept low to the end of that bit. A receiver that restarts at once would confirm a false start bit and then produce a spurious character or hang. The bench also sends single-bit data values (0x01 and 0x80) to catch a reversed bit order, and runs both parity senses at several divisors to catch an off-by-one in bit timing.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int MAX_BITS = 9;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic [MAX_BITS-1:0] data;
        logic                frame_err;
        logic                parity_err;
    } rx_char_t;

    // Expected parity bit: even parity gives XOR of data, odd inverts it.
    function automatic logic expected_parity(logic [MAX_BITS-1:0] d, logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= 1'b1;
                    else     stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= 1'b1;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/serial_rx_framer.sv
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8,
    parameter int DIV_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_s,
    input  logic [DIV_W-1:0] divisor,
    input  logic             par_en,
    input  logic             par_odd,
    output logic             char_valid,
    output rx_char_t         char_out
);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_BITS - 1);

    rx_state_e             state;
    logic [DIV_W-1:0]      cnt;
    logic [IDX_W-1:0]      idx;
    logic [DATA_BITS-1:0]  shreg;
    logic [MAX_BITS-1:0]   shreg_ext;
    logic                  perr_q;

    always_comb begin
        shreg_ext = '0;
        shreg_ext[DATA_BITS-1:0] = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= RX_IDLE;
            cnt        <= '0;
            idx        <= '0;
            shreg      <= '0;
            perr_q     <= 1'b0;
            char_valid <= 1'b0;
            char_out   <= '0;
        end else begin
            char_valid <= 1'b0;
            case (state)
                RX_IDLE: begin
                    if (!rx_s) begin
                        state <= RX_START;
                        cnt   <= divisor >> 1;
                    end
                end
                RX_START: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (rx_s) begin
                        state <= RX_IDLE;
                    end else begin
                        state  <= RX_DATA;
                        cnt    <= divisor;
                        idx    <= '0;
                        perr_q <= 1'b0;
                    end
                end
                RX_DATA: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        if (DATA_BITS > 1) shreg <= {rx_s, shreg[DATA_BITS-1:1]};
                        else               shreg <= rx_s;
                        cnt <= divisor;
                        if (idx == LAST_IDX) state <= par_en ? RX_PAR : RX_STOP;
                        else                 idx   <= idx + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        perr_q <= (rx_s != expected_parity(shreg_ext, par_odd));
                        cnt    <= divisor;
                        state  <= RX_STOP;
                    end
                end
                RX_STOP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else begin
                        char_valid          <= 1'b1;
                        char_out.data       <= shreg_ext;
                        char_out.frame_err  <= !rx_s;
                        char_out.parity_err <= perr_q;
                        state <= rx_s ? RX_IDLE : RX_WAIT_HIGH;
                    end
                end
                RX_WAIT_HIGH: begin
                    if (rx_s) state <= RX_IDLE;
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    // R1
    false_start_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_START && cnt == '0 && rx_s) |=> (state == RX_IDLE && !char_valid));

    // R8
    wait_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RX_STOP && cnt == '0 && !rx_s) |=> (state == RX_WAIT_HIGH && char_out.frame_err));

    // R4
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        char_valid |=> !char_valid);

endmodule

// File: rtl/serial_rx_hold.sv
module serial_rx_hold
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 char_valid,
    input  rx_char_t             char_in,
    input  logic                 rd_strobe,
    input  logic                 irq_en,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_ready,
    output logic                 overrun,
    output logic                 frame_err,
    output logic                 parity_err,
    output logic                 irq
);
    logic accept;
    assign accept = char_valid && (!rd_ready || rd_strobe);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data    <= '0;
            rd_ready   <= 1'b0;
            overrun    <= 1'b0;
            frame_err  <= 1'b0;
            parity_err <= 1'b0;
        end else begin
            if (accept) begin
                rd_data    <= char_in.data[DATA_BITS-1:0];
                frame_err  <= char_in.frame_err;
                parity_err <= char_in.parity_err;
                rd_ready   <= 1'b1;
            end else if (rd_strobe) begin
                rd_ready   <= 1'b0;
            end
            if (char_valid && rd_ready && !rd_strobe) overrun <= 1'b1;
            else if (rd_strobe)                       overrun <= 1'b0;
        end
    end

    assign irq = rd_ready & irq_en;

    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (char_valid && !rd_ready) |=> (rd_ready && rd_data == $past(char_in.data[DATA_BITS-1:0])));

    // R7
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (char_valid && rd_ready && !rd_strobe) |=> (overrun && $stable(rd_data) && $stable(frame_err)));

    // R6
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !char_valid) |=> (!rd_ready && !overrun && $stable(rd_data)));

endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf
    import serial_rx_pkg::*;
#(
    parameter int DATA_BITS   = 8,
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    input  logic [DIV_W-1:0]     divisor,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 irq_en,
    input  logic                 rd_strobe,
    output logic [DATA_BITS-1:0] rd_data,
    output logic                 rd_ready,
    output logic                 overrun,
    output logic                 frame_err,
    output logic                 parity_err,
    output logic                 irq
);
    logic     rx_s;
    logic     char_valid;
    rx_char_t char_bus;

    serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (rxd),
        .sync_out (rx_s)
    );

    serial_rx_framer #(.DATA_BITS(DATA_BITS), .DIV_W(DIV_W)) u_framer (
        .clk        (clk),
        .rst        (rst),
        .rx_s       (rx_s),
        .divisor    (divisor),
        .par_en     (parity_en),
        .par_odd    (parity_odd),
        .char_valid (char_valid),
        .char_out   (char_bus)
    );

    serial_rx_hold #(.DATA_BITS(DATA_BITS)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .char_valid (char_valid),
        .char_in    (char_bus),
        .rd_strobe  (rd_strobe),
        .irq_en     (irq_en),
        .rd_data    (rd_data),
        .rd_ready   (rd_ready),
        .overrun    (overrun),
        .frame_err  (frame_err),
        .parity_err (parity_err),
        .irq        (irq)
    );

    // R10
    irq_ready_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rd_ready && irq_en));

endmodule

// File: tb/tb_serial_rx_dbuf.sv
module tb_serial_rx_dbuf;
    localparam int CLK_PERIOD = 10;
    localparam int DBITS      = 8;
    localparam int WATCHDOG   = 150000;

    // {divisor[19:12], data[11:4], par_en[3], par_odd[2], bad_par[1], bad_stop[0]}
    localparam logic [19:0] VECS [0:7] = '{
        {8'd15, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd15, 8'h80, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'd4,  8'hA5, 1'b1, 1'b0, 1'b0, 1'b0},
        {8'd4,  8'h3C, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'd15, 8'h5A, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'd15, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b0},
        {8'd7,  8'h7E, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'd15, 8'h96, 1'b0, 1'b0, 1'b0, 1'b1}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             rxd = 1'b1;
    logic [15:0]      divisor = 16'd15;
    logic             parity_en = 1'b0;
    logic             parity_odd = 1'b0;
    logic             irq_en = 1'b0;
    logic             rd_strobe = 1'b0;
    logic [DBITS-1:0] rd_data;
    logic             rd_ready, overrun, frame_err, parity_err, irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_rx_dbuf #(.DATA_BITS(DBITS), .DIV_W(16), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .rxd(rxd), .divisor(divisor),
        .parity_en(parity_en), .parity_odd(parity_odd), .irq_en(irq_en),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_ready(rd_ready),
        .overrun(overrun), .frame_err(frame_err), .parity_err(parity_err), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic send_char(input logic [DBITS-1:0] d, input logic pen, input logic podd,
                             input logic bad_par, input logic bad_stop);
        int bt;
        bt = int'(divisor) + 1;
        rxd = 1'b0;
        wait_cyc(bt);
        for (int b = 0; b < DBITS; b++) begin
            rxd = d[b];
            wait_cyc(bt);
        end
        if (pen) begin
            rxd = (^d) ^ podd ^ bad_par;
            wait_cyc(bt);
        end
        rxd = !bad_stop;
        wait_cyc(bt);
        rxd = 1'b1;
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);
        // reset state
        check("R4 reset ready", rd_ready, 0);
        check("R7 reset overrun", overrun, 0);
        check("R10 reset irq", irq, 0);
        check("R8 reset frame_err", frame_err, 0);

        // table: R2 R3 R4 R6 R8 R9 R10
        for (int i = 0; i < 8; i++) begin
            divisor    = {8'd0, VECS[i][19:12]};
            parity_en  = VECS[i][3];
            parity_odd = VECS[i][2];
            send_char(VECS[i][11:4], VECS[i][3], VECS[i][2], VECS[i][1], VECS[i][0]);
            wait_cyc(int'(divisor) + 1);
            check("R4 R2 ready after frame", rd_ready, 1);
            check("R3 R2 data", rd_data, VECS[i][11:4]);
            check("R8 frame_err", frame_err, VECS[i][0]);
            check("R9 parity_err", parity_err, VECS[i][3] & VECS[i][1]);
            check("R7 no overrun", overrun, 0);
            check("R10 irq masked", irq, 0);
            host_read();
            check("R6 ready cleared", rd_ready, 0);
            check("R6 data kept", rd_data, VECS[i][11:4]);
        end

        // R1: short glitch then a valid frame
        divisor = 16'd15; parity_en = 1'b0;
        rxd = 1'b0; wait_cyc(3); rxd = 1'b1;
        wait_cyc(48);
        check("R1 glitch ignored", rd_ready, 0);
        send_char(8'h4D, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_cyc(16);
        check("R1 recovered ready", rd_ready, 1);
        check("R1 recovered data", rd_data, 8'h4D);
        host_read();

        // R5 R7: second frame while first unread
        send_char(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_cyc(16);
        fork
            send_char(8'hEE, 1'b0, 1'b0, 1'b0, 1'b1);
            begin
                wait_cyc(16 * 5);
                check("R5 data held mid-frame", rd_data, 8'h11);
            end
        join
        wait_cyc(16);
        check("R7 overrun set", overrun, 1);
        check("R7 old data kept", rd_data, 8'h11);
        check("R7 flags unchanged", frame_err, 0);
        check("R7 ready still", rd_ready, 1);
        host_read();
        check("R6 overrun cleared", overrun, 0);
        check("R6 ready cleared", rd_ready, 0);

        // R10: interrupt gating
        irq_en = 1'b1;
        check("R10 irq idle", irq, 0);
        send_char(8'h2B, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_cyc(16);
        check("R10 irq raised", irq, 1);
        irq_en = 1'b0;
        #1;
        check("R10 irq disabled", irq, 0);
        irq_en = 1'b1;
        host_read();
        check("R10 irq after read", irq, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule